// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Legality Checker

This block watches the control pins of a four-bank SDRAM: chip select, row strobe, column strobe, write enable, clock enable, A10 and the two bank-address pins. On every rising clock edge it turns those pins into a named command. It tracks whether each bank has an open row, and it keeps down-counters that measure how many cycles have passed since each timing-relevant event. It sits beside a memory controller or a bus monitor as a protocol watchdog.

For each edge, one cycle later, the block reports three things: the decoded command, the target bank, and an error code that names the first rule the command broke. All timing limits are parameters given in clock cycles. The defaults suit a 100 MHz clock.

Bank state and timers change only for commands that break no rule. One exception applies: an overdue-row report does not stop a command from taking effect.

Top module: `sdram_cmd_checker`

## Requirements
- R1: Decoding uses the pins sampled at an edge. If clock enable was low at the previous edge, or chip select is high, the command is NOP (code 0). Otherwise the pins {RAS,CAS,WE} decode as follows:
  - 000 gives MRS (1).
  - 001 gives REF (2) when clock enable is high now, and SREF (3) when clock enable is low now.
  - 011 gives ACT (4).
  - 101 gives RD (5), or RDA (6) when A10 is high.
  - 100 gives WR (7), or WRA (8) when A10 is high.
  - 110 gives BST (9).
  - 010 gives PRE (10), or PREA (11) when A10 is high.
  - 111 gives NOP.
- R2: `bank_o` is {ba[0], ba[1]}. Pins ba=00 select bank 0, ba[1] alone selects bank 1, ba[0] alone selects bank 2, and both select bank 3. `bank_o` reflects the pins for every command. PREA ignores it.
- R3: PREA closes every open bank. RDA and WRA close their bank when the command is issued. PRE to a bank that is already precharged is legal and changes nothing.
- R4: The outputs are registered. The result for the pins sampled at edge n appears after edge n. `illegal_o` is high exactly when `err_o` is nonzero. Reset gives NOP, bank 0 and error 0.
- R5: MRS, REF and SREF need every bank precharged, otherwise the error is NOT_IDLE (2). If any bank is still within its row-precharge time, the error is TRP (7).
- R6: Any command other than NOP within T_MRD edges after a legal MRS gives MRD (1). This check has the highest priority.
- R7: ACT to an open bank gives BANK_OPEN (3). RD, RDA, WR or WRA to a precharged bank gives BANK_IDLE (4).
- R8: An ACT has three timing checks, applied in this order. An ACT fewer than T_RP edges after its bank's precharge gives TRP (7). An ACT fewer than T_RC edges after that bank's last ACT or after a REF gives TRC (8). An ACT fewer than T_RRD edges after any ACT gives TRRD (9).
- R9: A read or write fewer than T_RCD edges after the bank's ACT gives TRCD (5). A precharge of an open bank fewer than T_RAS edges after its ACT gives TRAS (6).
- R10: After a WR at edge n, a precharge of that bank before edge n+BURST_LEN-1+T_WR gives TWR (10).
- R11: After an RDA or WRA at edge n, any read or write before edge n+BURST_LEN gives AP_LOCK (11). An ACT to that bank before n+BURST_LEN-1+T_RP gives TRP (7); for WRA the limit also adds T_WR.
- R12: If a bank has been open for more than T_RAS_MAX edges and the command breaks no other rule, the error is ROW_TIMEOUT (12).
- R13: A command that reports any error other than ROW_TIMEOUT leaves the bank state and all timers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| a10 | input | 1 | Auto-precharge / all-banks selector |
| ba | input | 2 | Bank address pins |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Target bank index |
| illegal_o | output | 1 | High when the command broke a rule |
| err_o | output | 4 | Code of the broken rule |

## Verification
A wrong bank-open bit or a timer left running does not show at the ports until a later command depends on it. It then appears as a wrong error code on that command, for example BANK_IDLE instead of legal, or a TRP that should have expired. The bench therefore places each probe on the exact edge where a limit starts or stops holding. It also follows every illegal command with a probe that would expose a state change, so that corrupted state is seen within one to a few cycles of the fault. Overdue-row tracking can only show after T_RAS_MAX edges, so that window is run out in full.

// File: rtl/sdr_chk_pkg.sv
package sdr_chk_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = 2;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_MRS  = 4'd1,
        CMD_REF  = 4'd2,
        CMD_SREF = 4'd3,
        CMD_ACT  = 4'd4,
        CMD_RD   = 4'd5,
        CMD_RDA  = 4'd6,
        CMD_WR   = 4'd7,
        CMD_WRA  = 4'd8,
        CMD_BST  = 4'd9,
        CMD_PRE  = 4'd10,
        CMD_PREA = 4'd11
    } cmd_e;

    typedef enum logic [3:0] {
        ERR_NONE        = 4'd0,
        ERR_MRD         = 4'd1,
        ERR_NOT_IDLE    = 4'd2,
        ERR_BANK_OPEN   = 4'd3,
        ERR_BANK_IDLE   = 4'd4,
        ERR_TRCD        = 4'd5,
        ERR_TRAS        = 4'd6,
        ERR_TRP         = 4'd7,
        ERR_TRC         = 4'd8,
        ERR_TRRD        = 4'd9,
        ERR_TWR         = 4'd10,
        ERR_AP_LOCK     = 4'd11,
        ERR_ROW_TIMEOUT = 4'd12
    } err_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
    } dec_t;

    typedef struct packed {
        logic open;
        logic rcd_busy;
        logic ras_busy;
        logic rp_busy;
        logic rc_busy;
        logic wr_busy;
        logic overdue;
    } bank_stat_t;

    function automatic logic [BANK_W-1:0] pins_to_bank(input logic [1:0] pins);
        return {pins[0], pins[1]};
    endfunction

    function automatic logic is_access(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
    endfunction

    function automatic logic is_auto_pre(input cmd_e c);
        return (c == CMD_RDA) || (c == CMD_WRA);
    endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_chk_pkg::*;
(
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       cke,
    input  logic       cke_q,
    input  logic       a10,
    input  logic [1:0] ba,
    output dec_t       dec_o
);

    always_comb begin
        dec_o.bank = pins_to_bank(ba);
        dec_o.cmd  = CMD_NOP;
        if (cke_q && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  dec_o.cmd = CMD_MRS;
                3'b001:  dec_o.cmd = cke ? CMD_REF : CMD_SREF;
                3'b011:  dec_o.cmd = CMD_ACT;
                3'b101:  dec_o.cmd = a10 ? CMD_RDA : CMD_RD;
                3'b100:  dec_o.cmd = a10 ? CMD_WRA : CMD_WR;
                3'b110:  dec_o.cmd = CMD_BST;
                3'b010:  dec_o.cmd = a10 ? CMD_PREA : CMD_PRE;
                default: dec_o.cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
    import sdr_chk_pkg::*;
#(
    parameter int T_RCD     = 2,
    parameter int T_RAS     = 5,
    parameter int T_RC      = 7,
    parameter int T_RP      = 2,
    parameter int T_WR      = 2,
    parameter int BURST_LEN = 4,
    parameter int T_RAS_MAX = 10000,
    parameter int CW        = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       act_i,
    input  logic       pre_i,
    input  logic       rd_i,
    input  logic       wr_i,
    input  logic       ap_i,
    input  logic       ref_i,
    output bank_stat_t st_o
);

    localparam int AW = $clog2(T_RAS_MAX + 1);
    localparam logic [CW-1:0] RCD_LD  = CW'(T_RCD - 1);
    localparam logic [CW-1:0] RAS_LD  = CW'(T_RAS - 1);
    localparam logic [CW-1:0] RC_LD   = CW'(T_RC - 1);
    localparam logic [CW-1:0] RP_LD   = CW'(T_RP - 1);
    localparam logic [CW-1:0] RDA_LD  = CW'(BURST_LEN + T_RP - 2);
    localparam logic [CW-1:0] WRA_LD  = CW'(BURST_LEN + T_WR + T_RP - 2);
    localparam logic [CW-1:0] WR_LD   = CW'(BURST_LEN + T_WR - 2);
    localparam logic [AW-1:0] AGE_MAX = AW'(T_RAS_MAX);

    logic          open_q;
    logic [CW-1:0] rcd_q, ras_q, rc_q, rp_q, wr_q;
    logic [AW-1:0] age_q;

    function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            rcd_q  <= '0;
            ras_q  <= '0;
            rc_q   <= '0;
            rp_q   <= '0;
            wr_q   <= '0;
            age_q  <= '0;
        end else begin
            rcd_q <= act_i ? RCD_LD : dn(rcd_q);
            ras_q <= act_i ? RAS_LD : dn(ras_q);
            rc_q  <= (act_i || ref_i) ? RC_LD : dn(rc_q);

            if (pre_i && open_q)  rp_q <= RP_LD;
            else if (rd_i && ap_i) rp_q <= RDA_LD;
            else if (wr_i && ap_i) rp_q <= WRA_LD;
            else                   rp_q <= dn(rp_q);

            wr_q <= (wr_i && !ap_i) ? WR_LD : dn(wr_q);

            if (act_i)
                open_q <= 1'b1;
            else if (pre_i || ((rd_i || wr_i) && ap_i))
                open_q <= 1'b0;

            if (act_i)
                age_q <= '0;
            else if (open_q && age_q != AGE_MAX)
                age_q <= age_q + 1'b1;
        end
    end

    always_comb begin
        st_o.open     = open_q;
        st_o.rcd_busy = (rcd_q != '0);
        st_o.ras_busy = (ras_q != '0);
        st_o.rp_busy  = (rp_q != '0);
        st_o.rc_busy  = (rc_q != '0);
        st_o.wr_busy  = (wr_q != '0);
        st_o.overdue  = open_q && (age_q >= AGE_MAX);
    end

    // R7
    access_open_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i || wr_i) |-> open_q);

    // R8
    act_timers_chk: assert property (@(posedge clk) disable iff (rst)
        act_i |-> (rp_q == '0 && rc_q == '0 && !open_q));

    // R13
    open_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(open_q) |-> $past(act_i));

endmodule

// File: rtl/sdr_global_timer.sv
module sdr_global_timer #(
    parameter int T_RRD     = 2,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4,
    parameter int CW        = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic act_go,
    input  logic mrs_go,
    input  logic ap_go,
    output logic cke_q,
    output logic rrd_busy,
    output logic mrd_busy,
    output logic aplock_busy
);

    localparam logic [CW-1:0] RRD_LD = CW'(T_RRD - 1);
    localparam logic [CW-1:0] MRD_LD = CW'(T_MRD - 1);
    localparam logic [CW-1:0] AP_LD  = CW'(BURST_LEN - 1);

    logic [CW-1:0] rrd_q, mrd_q, ap_q;

    function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q <= 1'b1;
            rrd_q <= '0;
            mrd_q <= '0;
            ap_q  <= '0;
        end else begin
            cke_q <= cke;
            rrd_q <= act_go ? RRD_LD : dn(rrd_q);
            mrd_q <= mrs_go ? MRD_LD : dn(mrd_q);
            ap_q  <= ap_go  ? AP_LD  : dn(ap_q);
        end
    end

    assign rrd_busy    = (rrd_q != '0);
    assign mrd_busy    = (mrd_q != '0);
    assign aplock_busy = (ap_q != '0);

endmodule

// File: rtl/sdr_rule_check.sv
module sdr_rule_check
    import sdr_chk_pkg::*;
(
    input  dec_t                         dec_i,
    input  bank_stat_t [NUM_BANKS-1:0]   st_i,
    input  logic                         rrd_busy,
    input  logic                         mrd_busy,
    input  logic                         aplock_busy,
    output err_e                         err_o,
    output logic                         overdue_o
);

    bank_stat_t sel;
    logic any_open, any_rp, any_ras, any_wr;

    always_comb begin
        sel       = st_i[dec_i.bank];
        any_open  = 1'b0;
        any_rp    = 1'b0;
        any_ras   = 1'b0;
        any_wr    = 1'b0;
        overdue_o = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            any_open  |= st_i[i].open;
            any_rp    |= st_i[i].rp_busy;
            any_ras   |= st_i[i].open && st_i[i].ras_busy;
            any_wr    |= st_i[i].open && st_i[i].wr_busy;
            overdue_o |= st_i[i].overdue;
        end
    end

    always_comb begin
        err_o = ERR_NONE;
        if (dec_i.cmd != CMD_NOP && mrd_busy) begin
            err_o = ERR_MRD;
        end else begin
            unique case (dec_i.cmd)
                CMD_MRS, CMD_REF, CMD_SREF: begin
                    if (any_open)    err_o = ERR_NOT_IDLE;
                    else if (any_rp) err_o = ERR_TRP;
                end
                CMD_ACT: begin
                    if (sel.open)          err_o = ERR_BANK_OPEN;
                    else if (sel.rp_busy)  err_o = ERR_TRP;
                    else if (sel.rc_busy)  err_o = ERR_TRC;
                    else if (rrd_busy)     err_o = ERR_TRRD;
                end
                CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
                    if (aplock_busy)       err_o = ERR_AP_LOCK;
                    else if (!sel.open)    err_o = ERR_BANK_IDLE;
                    else if (sel.rcd_busy) err_o = ERR_TRCD;
                end
                CMD_PRE: begin
                    if (sel.open && sel.ras_busy)     err_o = ERR_TRAS;
                    else if (sel.open && sel.wr_busy) err_o = ERR_TWR;
                end
                CMD_PREA: begin
                    if (any_ras)     err_o = ERR_TRAS;
                    else if (any_wr) err_o = ERR_TWR;
                end
                default: err_o = ERR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdr_chk_pkg::*;
#(
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RAS     = 5,
    parameter int T_RC      = 7,
    parameter int T_RRD     = 2,
    parameter int T_WR      = 2,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4,
    parameter int T_RAS_MAX = 10000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       cke,
    input  logic       a10,
    input  logic [1:0] ba,
    output logic [3:0] cmd_o,
    output logic [1:0] bank_o,
    output logic       illegal_o,
    output logic [3:0] err_o
);

    localparam int CW = $clog2(BURST_LEN + T_WR + T_RP + T_RC + T_RAS + T_RCD
                               + T_RRD + T_MRD + 1);

    dec_t                       dec;
    err_e                       cmd_err;
    err_e                       fin_err;
    logic                       overdue_any;
    logic                       go;
    logic                       cke_q, rrd_busy, mrd_busy, aplock_busy;
    bank_stat_t [NUM_BANKS-1:0] st;

    logic  act_go, mrs_go, ap_go, rw_go, ref_go;
    cmd_e  cmd_q;
    logic [BANK_W-1:0] bank_q;
    err_e  err_q;

    sdr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cke   (cke),
        .cke_q (cke_q),
        .a10   (a10),
        .ba    (ba),
        .dec_o (dec)
    );

    sdr_rule_check u_rules (
        .dec_i       (dec),
        .st_i        (st),
        .rrd_busy    (rrd_busy),
        .mrd_busy    (mrd_busy),
        .aplock_busy (aplock_busy),
        .err_o       (cmd_err),
        .overdue_o   (overdue_any)
    );

    assign go     = (cmd_err == ERR_NONE);
    assign act_go = go && (dec.cmd == CMD_ACT);
    assign mrs_go = go && (dec.cmd == CMD_MRS);
    assign ap_go  = go && is_auto_pre(dec.cmd);
    assign rw_go  = go && is_access(dec.cmd);
    assign ref_go = go && ((dec.cmd == CMD_REF) || (dec.cmd == CMD_SREF));

    sdr_global_timer #(
        .T_RRD     (T_RRD),
        .T_MRD     (T_MRD),
        .BURST_LEN (BURST_LEN),
        .CW        (CW)
    ) u_gtim (
        .clk         (clk),
        .rst         (rst),
        .cke         (cke),
        .act_go      (act_go),
        .mrs_go      (mrs_go),
        .ap_go       (ap_go),
        .cke_q       (cke_q),
        .rrd_busy    (rrd_busy),
        .mrd_busy    (mrd_busy),
        .aplock_busy (aplock_busy)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (dec.bank == BANK_W'(b));

        sdr_bank_track #(
            .T_RCD     (T_RCD),
            .T_RAS     (T_RAS),
            .T_RC      (T_RC),
            .T_RP      (T_RP),
            .T_WR      (T_WR),
            .BURST_LEN (BURST_LEN),
            .T_RAS_MAX (T_RAS_MAX),
            .CW        (CW)
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .act_i (act_go && hit),
            .pre_i (go && ((dec.cmd == CMD_PRE && hit) || dec.cmd == CMD_PREA)),
            .rd_i  (go && hit && (dec.cmd == CMD_RD || dec.cmd == CMD_RDA)),
            .wr_i  (go && hit && (dec.cmd == CMD_WR || dec.cmd == CMD_WRA)),
            .ap_i  (is_auto_pre(dec.cmd)),
            .ref_i (ref_go),
            .st_o  (st[b])
        );
    end

    assign fin_err = (cmd_err != ERR_NONE) ? cmd_err
                   : (overdue_any ? ERR_ROW_TIMEOUT : ERR_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            err_q  <= ERR_NONE;
        end else begin
            cmd_q  <= dec.cmd;
            bank_q <= dec.bank;
            err_q  <= fin_err;
        end
    end

    assign cmd_o     = cmd_q;
    assign bank_o    = bank_q;
    assign err_o     = err_q;
    assign illegal_o = (err_q != ERR_NONE);

    // R11
    ap_lock_chk: assert property (@(posedge clk) disable iff (rst)
        aplock_busy |-> !rw_go);

    if (T_MRD >= 2) begin : g_mrd_chk
        // R6
        mrs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            mrs_go |=> !(go && dec.cmd != CMD_NOP));
    end

    if (T_RC >= 2) begin : g_rc_chk
        // R8
        act_same_bank_chk: assert property (@(posedge clk) disable iff (rst)
            act_go |=> !(act_go && dec.bank == $past(dec.bank)));
    end

endmodule

// File: tb/sdram_cmd_checker_bench.sv
module sdram_cmd_checker_bench;
    import sdr_chk_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       cke = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'b00;
    logic [3:0] cmd_o, err_o;
    logic [1:0] bank_o;
    logic       illegal_o;

    int tests_run    = 0;
    int tests_failed = 0;

    typedef struct {
        logic [3:0] c;
        logic [1:0] b;
        logic [3:0] e;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    sdram_cmd_checker u_sdram_cmd_checker (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .cke       (cke),
        .a10       (a10),
        .ba        (ba),
        .cmd_o     (cmd_o),
        .bank_o    (bank_o),
        .illegal_o (illegal_o),
        .err_o     (err_o)
    );

    // Monitor: pops one expected item per cycle, half a period after the edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            tests_run++;
            if (cmd_o !== e.c || bank_o !== e.b || err_o !== e.e ||
                illegal_o !== (e.e != 4'd0)) begin
                tests_failed++;
                $display("FAIL %s: actual cmd=%0d bank=%0d err=%0d ill=%0b, expected cmd=%0d bank=%0d err=%0d ill=%0b",
                         e.tag, cmd_o, bank_o, err_o, illegal_o, e.c, e.b, e.e, (e.e != 4'd0));
            end
        end
    end

    task automatic step(input logic cs, input logic r, input logic c, input logic w,
                        input logic ck, input logic ap, input logic [1:0] bk,
                        input cmd_e ec, input err_e ee, input string tag);
        @(negedge clk);
        cs_n = cs; ras_n = r; cas_n = c; we_n = w; cke = ck; a10 = ap;
        ba = {bk[0], bk[1]};
        @(posedge clk);
        exp_q.push_back('{ec, bk, ee, tag});
    endtask

    task automatic t_nop(input err_e ee, input string tag);
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, CMD_NOP, ee, tag);
    endtask
    task automatic nops(input int n, input string tag);
        for (int i = 0; i < n; i++) t_nop(ERR_NONE, tag);
    endtask
    task automatic t_mrs(input err_e ee, input string tag);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, CMD_MRS, ee, tag);
    endtask
    task automatic t_ref(input logic ck, input err_e ee, input string tag);
        step(1'b0, 1'b0, 1'b0, 1'b1, ck, 1'b0, 2'd0, ck ? CMD_REF : CMD_SREF, ee, tag);
    endtask
    task automatic t_act(input logic [1:0] b, input err_e ee, input string tag);
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, b, CMD_ACT, ee, tag);
    endtask
    task automatic t_rd(input logic [1:0] b, input logic ap, input err_e ee, input string tag);
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, ap, b, ap ? CMD_RDA : CMD_RD, ee, tag);
    endtask
    task automatic t_wr(input logic [1:0] b, input logic ap, input err_e ee, input string tag);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, ap, b, ap ? CMD_WRA : CMD_WR, ee, tag);
    endtask
    task automatic t_pre(input logic [1:0] b, input err_e ee, input string tag);
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, b, CMD_PRE, ee, tag);
    endtask
    task automatic t_prea(input logic [1:0] b, input err_e ee, input string tag);
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, b, CMD_PREA, ee, tag);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R4 reset state
        tests_run++;
        if (cmd_o !== 4'd0 || bank_o !== 2'd0 || err_o !== 4'd0 || illegal_o !== 1'b0) begin
            tests_failed++;
            $display("FAIL R4 reset: actual cmd=%0d bank=%0d err=%0d, expected 0 0 0",
                     cmd_o, bank_o, err_o);
        end

        t_mrs(ERR_NONE, "R1 mode set idle");
        t_act(2'd0, ERR_MRD, "R6 act right after mode set");
        t_act(2'd0, ERR_NONE, "R13 bank A unchanged after rejected act");
        t_rd(2'd0, 1'b0, ERR_TRCD, "R9 read one cycle after act");
        t_act(2'd0, ERR_BANK_OPEN, "R7 act to open bank");
        t_act(2'd1, ERR_NONE, "R2 bank B act");
        t_act(2'd2, ERR_TRRD, "R8 act other bank too soon");
        t_wr(2'd1, 1'b0, ERR_NONE, "R1 write bank B");
        t_pre(2'd0, ERR_NONE, "R9 precharge after tRAS");
        t_act(2'd0, ERR_TRP, "R8 act inside tRP");
        t_pre(2'd1, ERR_TWR, "R10 precharge inside write recovery");
        t_rd(2'd0, 1'b0, ERR_BANK_IDLE, "R7 read precharged bank");
        t_pre(2'd1, ERR_NONE, "R10 precharge at write recovery limit");
        t_ref(1'b1, ERR_TRP, "R5 refresh inside tRP");
        t_ref(1'b1, ERR_NONE, "R5 refresh all idle");
        t_act(2'd3, ERR_TRC, "R8 act inside tRC after refresh");
        t_rd(2'd2, 1'b0, ERR_BANK_IDLE, "R13 bank C still idle");
        nops(4, "R1 nop");
        t_act(2'd3, ERR_NONE, "R8 act at tRC limit");
        t_ref(1'b1, ERR_NOT_IDLE, "R5 refresh with open bank");
        t_mrs(ERR_NOT_IDLE, "R5 mode set with open bank");
        t_rd(2'd3, 1'b1, ERR_NONE, "R3 read auto-precharge");
        t_wr(2'd3, 1'b0, ERR_AP_LOCK, "R11 write during auto-pre burst");
        nops(1, "R1 nop");
        t_act(2'd3, ERR_TRP, "R11 act before read auto-pre recovery");
        t_rd(2'd3, 1'b0, ERR_BANK_IDLE, "R11 bank closed by auto-pre");
        t_act(2'd3, ERR_NONE, "R11 act at read auto-pre limit");
        t_wr(2'd3, 1'b1, ERR_TRCD, "R9 write auto-pre too soon");
        t_wr(2'd3, 1'b1, ERR_NONE, "R3 write auto-precharge");
        nops(5, "R1 nop");
        t_act(2'd3, ERR_TRP, "R11 act before write auto-pre recovery");
        t_act(2'd3, ERR_NONE, "R11 act at write auto-pre limit");
        t_prea(2'd2, ERR_TRAS, "R9 all-bank precharge inside tRAS");
        nops(3, "R1 nop");
        t_prea(2'd2, ERR_NONE, "R3 all-bank precharge");
        t_pre(2'd3, ERR_NONE, "R3 precharge of idle bank");
        t_act(2'd1, ERR_NONE, "R12 open bank B");
        nops(10000, "R12 row within limit");
        t_nop(ERR_ROW_TIMEOUT, "R12 row overdue");
        t_pre(2'd1, ERR_ROW_TIMEOUT, "R12 late precharge still closes");
        t_ref(1'b0, ERR_TRP, "R5 self refresh inside tRP");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, CMD_NOP, ERR_NONE, "R1 clock enable low");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, CMD_NOP, ERR_NONE, "R1 clock enable exit");
        t_ref(1'b0, ERR_NONE, "R5 self refresh entry");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, CMD_NOP, ERR_NONE, "R1 act pins while clock disabled");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, CMD_NOP, ERR_NONE, "R1 self refresh exit");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, CMD_BST, ERR_NONE, "R1 burst stop");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, CMD_NOP, ERR_NONE, "R1 deselect");

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule